// File: doc/BRIEF.md
# Move-Only 8-bit CPU Core

This block is a compact processor core whose only instruction is a move. Every 8-bit opcode names a destination and a source on one internal bus. The source selects what drives the bus: a general register, the immediate latch, the difference A minus B, or the bitwise NOR of A and B. The destination selects which register captures the bus. Three destination codes are reserved for control. One loads an immediate value from the next program word. One jumps when carry is clear. One jumps unconditionally. In each jump case the bus value becomes the new program counter.

The core fetches one word per clock from an external program ROM through an address output and a data input. An instruction completes on the rising edge that follows its fetch. A load-immediate takes two clocks, because the second word is data. The `run` input pauses the core when low; nothing changes while it is held low. Addition is built from subtraction: load B with all ones, then read A minus B to get A plus one.

Top module: `mvcore`

## Requirements
- R1: An opcode is split into a destination code in bits 7:4 and a source code in bits 3:0. Register n is destination code n and source code n (A=0, B=1, C=2, D=3), so 0x10 copies A into B and 0x01 copies B into A.
- R2: While `rst` is high on a rising edge, the program counter, the carry flag, the immediate latch and every register are cleared to zero.
- R3: With `run` high and no taken jump, `rom_addr` rises by one per clock and wraps from all ones to zero. With `run` low, no state changes.
- R4: Destination code 0xD (load-immediate) writes no register. The program word that follows it is captured into the immediate latch and is not executed, and the counter steps past both words. The source field of this opcode is ignored.
- R5: Source code 0xD places the immediate latch on the bus.
- R6: Source code 0xE yields A minus B modulo 2^DW. Source code 0xF yields the bitwise NOR of A and B.
- R7: Carry changes only when the source is 0xE and the destination is a register. It becomes 1 when A >= B (no borrow) and 0 otherwise.
- R8: Destination code 0xE loads the counter from the bus when carry is 0; when carry is 1 the counter steps by one.
- R9: Destination code 0xF always loads the counter from the bus.
- R10: A source code with no register, latch or arithmetic result behind it drives 0 onto the bus. A destination code with no register behind it changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Execute when high, hold all state when low |
| rom_addr | output | AW | Program ROM address (the program counter) |
| rom_data | input | DW | Program ROM word at `rom_addr` |

## Verification
The bench builds the core with DW = 8, AW = 8 and four registers. With AW equal to DW, a jump through any source copies the full bus value onto `rom_addr`, so register contents, the immediate latch and the carry flag can all be observed at the ROM port. With four registers, source codes 4 to 12 are unassigned and open to direct probing. A 16 by 16 grid of operand pairs, stepping by 0x11 so that it includes equal pairs, zero and 0xFF, exercises the difference, the NOR and the carry against arithmetic computed in the bench.

// File: rtl/mvc_pkg.sv
package mvc_pkg;
   localparam int OP_W  = 8;
   localparam int FLD_W = 4;
   localparam int MAX_REGS = 13;

   localparam logic [FLD_W-1:0] DST_LDI = 4'hD;
   localparam logic [FLD_W-1:0] DST_JNC = 4'hE;
   localparam logic [FLD_W-1:0] DST_JMP = 4'hF;

   localparam logic [FLD_W-1:0] SRC_IMM = 4'hD;
   localparam logic [FLD_W-1:0] SRC_SUB = 4'hE;
   localparam logic [FLD_W-1:0] SRC_NOR = 4'hF;

   typedef struct packed {
      logic [FLD_W-1:0] dst;
      logic [FLD_W-1:0] src;
   } op_t;
endpackage

// File: rtl/mvc_decode.sv
module mvc_decode
   import mvc_pkg::*;
#(
   parameter int NREG = 4
) (
   input  logic             active,
   input  logic [FLD_W-1:0] dst,
   output logic [NREG-1:0]  wr_sel,
   output logic             wr_en,
   output logic             ldi,
   output logic             jmp,
   output logic             jnc
);
   // one write strobe per implemented register
   for (genvar g = 0; g < NREG; g++) begin : g_strobe
      assign wr_sel[g] = active && (dst == FLD_W'(g));
   end

   assign wr_en = |wr_sel;
   assign ldi   = active && (dst == DST_LDI);
   assign jmp   = active && (dst == DST_JMP);
   assign jnc   = active && (dst == DST_JNC);
endmodule

// File: rtl/mvc_regfile.sv
module mvc_regfile
   import mvc_pkg::*;
#(
   parameter int DW   = 8,
   parameter int NREG = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NREG-1:0]  wr_sel,
   input  logic [DW-1:0]    wdata,
   input  logic [FLD_W-1:0] rd_src,
   output logic [DW-1:0]    rd_data,
   output logic [DW-1:0]    reg_a,
   output logic [DW-1:0]    reg_b
);
   logic [DW-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            regs[g] <= '0;
         else if (wr_sel[g])
            regs[g] <= wdata;
      end
   end

   // unimplemented codes read as zero
   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NREG; k++)
         if (rd_src == FLD_W'(k))
            rd_data = regs[k];
   end

   assign reg_a = regs[0];
   assign reg_b = regs[1];
endmodule

// File: rtl/mvc_alu.sv
module mvc_alu #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] diff,
   output logic [DW-1:0] nor_ab,
   output logic          no_borrow
);
   logic borrow;

   assign {borrow, diff} = {1'b0, a} - {1'b0, b};
   assign no_borrow      = ~borrow;
   assign nor_ab         = ~(a | b);
endmodule

// File: rtl/mvc_pc.sv
module mvc_pc #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  logic          load,
   input  logic [AW-1:0] target,
   output logic [AW-1:0] pc
);
   always_ff @(posedge clk) begin
      if (rst)
         pc <= '0;
      else if (adv)
         pc <= load ? target : pc + 1'b1;
   end
endmodule

// File: rtl/mvcore.sv
module mvcore
   import mvc_pkg::*;
#(
   parameter int DW   = 8,
   parameter int AW   = 8,
   parameter int NREG = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          run,
   output logic [AW-1:0] rom_addr,
   input  logic [DW-1:0] rom_data
);
   // elaboration-time parameter checks
   if (DW < OP_W) begin : g_bad_dw
      $error("mvcore: DW must hold an opcode");
   end
   if (NREG < 2 || NREG > MAX_REGS) begin : g_bad_nreg
      $error("mvcore: NREG out of range");
   end
   if (AW < 1) begin : g_bad_aw
      $error("mvcore: AW must be positive");
   end

   op_t           op;
   logic          pend;
   logic          active;
   logic          carry;
   logic [DW-1:0] imm;
   logic [DW-1:0] bus;
   logic [DW-1:0] rd_data, reg_a, reg_b, diff, nor_ab;
   logic [AW-1:0] bus_tgt;
   logic [NREG-1:0] wr_sel;
   logic          wr_en, ldi, jmp, jnc, no_borrow, taken, sub_wr;

   assign op     = op_t'(rom_data[OP_W-1:0]);
   assign active = run && !pend;

   mvc_decode #(.NREG(NREG)) u_dec (
      .active (active),
      .dst    (op.dst),
      .wr_sel (wr_sel),
      .wr_en  (wr_en),
      .ldi    (ldi),
      .jmp    (jmp),
      .jnc    (jnc)
   );

   mvc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .wr_sel  (wr_sel),
      .wdata   (bus),
      .rd_src  (op.src),
      .rd_data (rd_data),
      .reg_a   (reg_a),
      .reg_b   (reg_b)
   );

   mvc_alu #(.DW(DW)) u_alu (
      .a         (reg_a),
      .b         (reg_b),
      .diff      (diff),
      .nor_ab    (nor_ab),
      .no_borrow (no_borrow)
   );

   // source select onto the shared bus
   always_comb begin
      unique case (op.src)
         SRC_IMM: bus = imm;
         SRC_SUB: bus = diff;
         SRC_NOR: bus = nor_ab;
         default: bus = rd_data;
      endcase
   end

   // fit the bus to the address width
   if (AW <= DW) begin : g_tgt_trunc
      assign bus_tgt = bus[AW-1:0];
   end else begin : g_tgt_ext
      assign bus_tgt = {{(AW-DW){1'b0}}, bus};
   end

   assign sub_wr = wr_en && (op.src == SRC_SUB);
   assign taken  = jmp || (jnc && !carry);

   always_ff @(posedge clk) begin
      if (rst) begin
         pend  <= 1'b0;
         imm   <= '0;
         carry <= 1'b0;
      end else if (run) begin
         pend <= ldi;
         if (pend)
            imm <= rom_data;
         if (sub_wr)
            carry <= no_borrow;
      end
   end

   mvc_pc #(.AW(AW)) u_pc (
      .clk    (clk),
      .rst    (rst),
      .adv    (run),
      .load   (taken),
      .target (bus_tgt),
      .pc     (rom_addr)
   );
endmodule

// File: rtl/mvcore_chk.sv
module mvcore_chk #(
   parameter int DW = 8,
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          run,
   input logic          pend,
   input logic          carry,
   input logic          wr_en,
   input logic          sub_wr,
   input logic          no_borrow,
   input logic          taken,
   input logic [AW-1:0] bus_tgt,
   input logic [AW-1:0] rom_addr,
   input logic [DW-1:0] rom_data,
   input logic [DW-1:0] imm
);
   // R2
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (rom_addr == '0) && !carry && (imm == '0) && !pend);

   // R3
   run_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !run |=> $stable(rom_addr) && $stable(carry) && $stable(imm) && $stable(pend));

   // R3
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (run && !taken) |=> rom_addr == AW'($past(rom_addr) + 1'b1));

   // R9
   jump_load_chk: assert property (@(posedge clk) disable iff (rst)
      (run && taken) |=> rom_addr == $past(bus_tgt));

   // R4
   imm_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (run && pend) |=> imm == $past(rom_data));

   // R4
   ldi_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
      pend |-> !wr_en && !taken);

   // R7
   carry_update_chk: assert property (@(posedge clk) disable iff (rst)
      (run && sub_wr) |=> carry == $past(no_borrow));

   // R7
   carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !sub_wr |=> $stable(carry));
endmodule

bind mvcore mvcore_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .run       (run),
   .pend      (pend),
   .carry     (carry),
   .wr_en     (wr_en),
   .sub_wr    (sub_wr),
   .no_borrow (no_borrow),
   .taken     (taken),
   .bus_tgt   (bus_tgt),
   .rom_addr  (rom_addr),
   .rom_data  (rom_data),
   .imm       (imm)
);

// File: tb/sim_mvcore.sv
`timescale 1ns/1ps
module sim_mvcore;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       run = 1'b1;
   logic [7:0] rom_addr;
   logic [7:0] rom_data;
   logic [7:0] rom [256];
   int         nchk = 0;
   int         nfail = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   assign rom_data = rom[rom_addr];

   mvcore #(.DW(8), .AW(8), .NREG(4)) u0 (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .rom_addr (rom_addr),
      .rom_data (rom_data)
   );

   task automatic clear_rom();
      for (int i = 0; i < 256; i++) rom[i] = 8'h00;
   endtask

   task automatic restart();
      rst = 1'b1;
      run = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] exp);
      nchk++;
      if (rom_addr !== exp) begin
         nfail++;
         $display("FAIL %s: rom_addr=%h expected %h", req, rom_addr, exp);
      end
   endtask

   // A=0x55, B=0x10, C=A-B (carry set), imm=0x10
   task automatic dirty_state();
      clear_rom();
      rom[0] = 8'hD0; rom[1] = 8'h55; rom[2] = 8'h0D;
      rom[3] = 8'hD0; rom[4] = 8'h10; rom[5] = 8'h1D;
      rom[6] = 8'h2E;
      restart();
      step(7);
   endtask

   // operand sweep program; mode 0: JMP A-B, 1: JNC B after SUB, 2: JMP NOR
   task automatic sweep_one(input logic [7:0] a, input logic [7:0] b, input int mode);
      logic [7:0] exp;
      clear_rom();
      rom[0] = 8'hD0; rom[1] = a; rom[2] = 8'h0D;
      rom[3] = 8'hD0; rom[4] = b; rom[5] = 8'h1D;
      rom[6] = (mode == 2) ? 8'h2F : 8'h2E;
      rom[7] = (mode == 1) ? 8'hE1 : 8'hF2;
      restart();
      step(8);
      case (mode)
         0: begin exp = a - b;               check("R6 difference", exp); end
         1: begin exp = (a >= b) ? 8'd8 : b; check("R7/R8 carry and conditional jump", exp); end
         default: begin exp = ~(a | b);      check("R6 nor", exp); end
      endcase
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      // R2: reset clears counter, registers, latch and carry
      dirty_state();
      rom[0] = 8'hF0;
      rst = 1'b1;
      step(2);
      check("R2 counter during reset", 8'h00);
      rst = 1'b0;
      step(1);
      check("R2 register A cleared", 8'h00);

      dirty_state();
      rom[0] = 8'hFD;
      restart();
      step(1);
      check("R2 immediate cleared", 8'h00);

      dirty_state();
      rom[0] = 8'hED;
      restart();
      step(1);
      check("R2 carry cleared", 8'h00);

      // R1: move chain A<-imm, B<-A, C<-B, D<-C, JMP D
      clear_rom();
      rom[0] = 8'hD0; rom[1] = 8'h5A; rom[2] = 8'h0D; rom[3] = 8'h10;
      rom[4] = 8'h21; rom[5] = 8'h32; rom[6] = 8'hF3;
      restart();
      step(7);
      check("R1 move chain", 8'h5A);

      // R3: plain stepping and wrap
      clear_rom();
      restart();
      step(10);
      check("R3 increment", 8'd10);
      step(246);
      check("R3 wrap", 8'h00);

      // R3: run low holds state
      clear_rom();
      rom[0] = 8'hD0; rom[1] = 8'h40; rom[2] = 8'h0D; rom[3] = 8'hF0;
      restart();
      step(1);
      run = 1'b0;
      step(4);
      check("R3 hold counter", 8'h01);
      run = 1'b1;
      step(3);
      check("R3 resume after hold", 8'h40);

      // R4/R5: immediate word skipped, source field ignored, latch readable
      clear_rom();
      rom[0] = 8'hD7; rom[1] = 8'hF0; rom[2] = 8'hFD;
      restart();
      step(2);
      check("R4 immediate word not executed", 8'h02);
      step(1);
      check("R5 jump through immediate", 8'hF0);

      // R10: unassigned source reads zero
      clear_rom();
      rom[0] = 8'hD0; rom[1] = 8'h33; rom[2] = 8'h0D; rom[3] = 8'h08; rom[4] = 8'hF0;
      restart();
      step(5);
      check("R10 unassigned source", 8'h00);

      // R10/R7: unassigned destination with SUB source leaves carry clear
      clear_rom();
      rom[0] = 8'hD0; rom[1] = 8'h20; rom[2] = 8'h0D; rom[3] = 8'h5E; rom[4] = 8'hED;
      restart();
      step(5);
      check("R10 unassigned destination", 8'h20);

      // R7: non-SUB write keeps carry set
      clear_rom();
      rom[0] = 8'hD0; rom[1] = 8'h30; rom[2] = 8'h0D;
      rom[3] = 8'hD0; rom[4] = 8'h10; rom[5] = 8'h1D;
      rom[6] = 8'h2E; rom[7] = 8'h30; rom[8] = 8'hE1;
      restart();
      step(9);
      check("R7 carry kept by plain move", 8'h09);

      // R9: unconditional jump regardless of carry
      clear_rom();
      rom[0] = 8'hD0; rom[1] = 8'h90; rom[2] = 8'h0D;
      rom[3] = 8'h2E; rom[4] = 8'hF0;
      restart();
      step(5);
      check("R9 unconditional jump", 8'h90);

      // R6/R7/R8: operand grid
      for (int i = 0; i < 16; i++)
         for (int j = 0; j < 16; j++)
            for (int m = 0; m < 3; m++)
               sweep_one(8'(i * 17), 8'(j * 17), m);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule